// File: doc/BRIEF.md
# Page-Buffered Write Path with Word Address Counter

This block sits behind a two-wire serial memory slave and owns the word address counter and a 16-byte staging buffer for a 256-byte storage array. A bus front end decodes the serial traffic and drives four single-cycle strobes. One loads the counter from a received word address. One accepts a data byte during a write burst. One moves the counter on after a byte has been read. One commits the staged bytes to the array when the bus stop arrives.

During a write burst, data bytes land in the buffer slot named by the low four counter bits. Only those four bits count, so a burst stays inside its 16-byte page and wraps to the page's first slot. A per-slot valid mask records which slots were filled. At commit, only the filled slots are copied, so a partial page leaves its other bytes unchanged. Two protection inputs, one for each half of the array, can block each byte's commit.

Reads use the same counter. The read data output always shows the array byte at the counter. The read-advance strobe moves the counter across the whole 256-byte space, rolling from 255 to 0. The array is a plain register file. Storage programming time is not modelled.

Top module: `pgwb_top`

## Requirements
- R1: After reset the counter is 0x00, every array byte is 0x00 and the read data output is 0x00.
- R2: A load strobe sets the counter to the presented 8-bit word address at the next clock edge, and opens a new burst whose page is the upper four bits of that address.
- R3: A data strobe stores the byte into the buffer slot given by counter bits [3:0]. It then increments only those four bits, so 0x9F becomes 0x90 while bits [7:4] stay unchanged.
- R4: When more than 16 data bytes arrive in one burst, a later byte replaces the earlier byte held in the same slot. The commit writes the last value received for each slot.
- R5: A commit copies only the slots filled since the burst opened, into array address {page, slot}; all other array bytes keep their previous values.
- R6: A commit leaves the counter unchanged, so afterwards it points one past the last byte written, wrapped within the page.
- R7: A read-advance strobe increments the full 8-bit counter, rolling from 0xFF to 0x00.
- R8: The read data output equals the array byte at the current counter value in the same cycle the counter takes that value.
- R9: At commit, a byte in the lower half (address bit 7 = 0) is written only when the lower-half permit input is 1. A byte in the upper half (bit 7 = 1) is written only when the upper-half permit input is 1. A blocked commit leaves the array byte unchanged.
- R10: The valid mask clears on every load strobe and every commit, blocked or not. Bytes staged before a reload, and a repeated commit with no new data, write nothing.
- R11: When strobes coincide, only the highest-priority one takes effect. The order is load, then data, then read-advance, then commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_addr_i | input | 1 | Load word address strobe; opens a write burst |
| addr_i | input | 8 | Word address received from the bus |
| wr_byte_i | input | 1 | Data byte strobe for a write burst |
| wdata_i | input | 8 | Data byte received from the bus |
| rd_adv_i | input | 1 | Advance counter after a byte is read |
| commit_i | input | 1 | Copy the staged bytes into the array (bus stop) |
| perm_lo_i | input | 1 | Write permit for addresses 0x00-0x7F |
| perm_hi_i | input | 1 | Write permit for addresses 0x80-0xFF |
| ptr_o | output | 8 | Current word address counter |
| rdata_o | output | 8 | Array byte at the counter |

## Verification
Write bursts are tried in four shapes. A single byte shows that commit touches nothing else. A burst that starts near the end of a page shows the four-bit wrap, as opposed to a full-width carry. An 18-byte burst shows that the last value per slot wins. A burst that is abandoned by a reload shows that the mask clears. Reads cross the 0xFF boundary to separate the full-width roll of the read path from the page wrap of the write path. The two permit inputs are cleared one at a time against bytes in each half, and then a second commit is issued. This tells a blocked byte apart from a byte left pending in the mask.

// File: rtl/pgwb_pkg.sv
package pgwb_pkg;

  // One decoded action per cycle; strobes are reduced to this by priority.
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_DATA   = 3'd2,
    OP_NEXT   = 3'd3,
    OP_COMMIT = 3'd4
  } pgwb_op_e;

endpackage

// File: rtl/pgwb_ptr.sv
module pgwb_ptr
  import pgwb_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pgwb_op_e      op,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic [PW-1:0] slot_inc;

  assign slot_inc = ptr_q[PW-1:0] + {{(PW-1){1'b0}}, 1'b1};

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    unique case (op)
      OP_LOAD: begin
        ptr_d  = load_addr;
        ptr_en = 1'b1;
      end
      OP_DATA: begin
        ptr_d  = {ptr_q[AW-1:PW], slot_inc};
        ptr_en = 1'b1;
      end
      OP_NEXT: begin
        ptr_d  = ptr_q + {{(AW-1){1'b0}}, 1'b1};
        ptr_en = 1'b1;
      end
      default: begin
        ptr_d  = ptr_q;
        ptr_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/pgwb_buf.sv
module pgwb_buf
  import pgwb_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int DW = 8,
  localparam int DEPTH  = 1 << PW,
  localparam int PAGE_W = AW - PW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  pgwb_op_e                    op,
  input  logic [PAGE_W-1:0]           load_page,
  input  logic [PW-1:0]               slot,
  input  logic [DW-1:0]               wdata,
  output logic [PAGE_W-1:0]           page,
  output logic [DEPTH-1:0]            mask,
  output logic [DEPTH-1:0][DW-1:0]    data
);

  logic [PAGE_W-1:0]        page_q;
  logic [DEPTH-1:0]         mask_q, mask_d;
  logic                     mask_en;
  logic [DEPTH-1:0][DW-1:0] data_q;

  // page register: captured when a burst opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (op == OP_LOAD) begin
      page_q <= load_page;
    end
  end

  // valid mask
  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    unique case (op)
      OP_LOAD, OP_COMMIT: begin
        mask_d  = '0;
        mask_en = 1'b1;
      end
      OP_DATA: begin
        mask_d       = mask_q;
        mask_d[slot] = 1'b1;
        mask_en      = 1'b1;
      end
      default: begin
        mask_d  = mask_q;
        mask_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  // slot storage, one enable per slot
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = (op == OP_DATA) && (slot == PW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[s] <= '0;
      end else if (slot_en) begin
        data_q[s] <= wdata;
      end
    end
  end

  assign page = page_q;
  assign mask = mask_q;
  assign data = data_q;

endmodule

// File: rtl/pgwb_array.sv
module pgwb_array #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int DW = 8,
  localparam int DEPTH  = 1 << PW,
  localparam int PAGE_W = AW - PW,
  localparam int WORDS  = 1 << AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PAGE_W-1:0]        wr_page,
  input  logic [DEPTH-1:0]         slot_we,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data
);

  logic [DW-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [PAGE_W-1:0] PG_ID = PAGE_W'(w >> PW);
    localparam int                SL    = w % DEPTH;
    logic word_en;
    assign word_en = slot_we[SL] && (wr_page == PG_ID);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '0;
      end else if (word_en) begin
        mem_q[w] <= slot_data[SL];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pgwb_top.sv
module pgwb_top
  import pgwb_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_byte_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_adv_i,
  input  logic          commit_i,
  input  logic          perm_lo_i,
  input  logic          perm_hi_i,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH  = 1 << PW;
  localparam int PAGE_W = AW - PW;

  pgwb_op_e                 op;
  logic [AW-1:0]            ptr;
  logic [PAGE_W-1:0]        page;
  logic [DEPTH-1:0]         mask;
  logic [DEPTH-1:0][DW-1:0] bdata;
  logic                     half_ok;
  logic [DEPTH-1:0]         slot_we;

  // strobe priority: load > data > read-advance > commit
  always_comb begin
    if (ld_addr_i)      op = OP_LOAD;
    else if (wr_byte_i) op = OP_DATA;
    else if (rd_adv_i)  op = OP_NEXT;
    else if (commit_i)  op = OP_COMMIT;
    else                op = OP_IDLE;
  end

  pgwb_ptr #(.AW(AW), .PW(PW)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .load_addr (addr_i),
    .ptr       (ptr)
  );

  pgwb_buf #(.AW(AW), .PW(PW), .DW(DW)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .load_page (addr_i[AW-1:PW]),
    .slot      (ptr[PW-1:0]),
    .wdata     (wdata_i),
    .page      (page),
    .mask      (mask),
    .data      (bdata)
  );

  // a page never straddles the halves, so one permit covers the page
  assign half_ok = page[PAGE_W-1] ? perm_hi_i : perm_lo_i;
  assign slot_we = mask & {DEPTH{(op == OP_COMMIT) && half_ok}};

  pgwb_array #(.AW(AW), .PW(PW), .DW(DW)) arr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_page   (page),
    .slot_we   (slot_we),
    .slot_data (bdata),
    .rd_addr   (ptr),
    .rd_data   (rdata_o)
  );

  assign ptr_o = ptr;

endmodule

// File: rtl/pgwb_chk.sv
module pgwb_chk #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_addr_i,
  input logic [AW-1:0] addr_i,
  input logic          wr_byte_i,
  input logic          rd_adv_i,
  input logic          commit_i,
  input logic          perm_lo_i,
  input logic          perm_hi_i,
  input logic [AW-1:0] ptr_o,
  input logic [DW-1:0] rdata_o
);

  // R2
  load_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr_i |=> ptr_o == $past(addr_i));

  // R3
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_i && !ld_addr_i) |=>
      (ptr_o[AW-1:PW] == $past(ptr_o[AW-1:PW])) &&
      (ptr_o[PW-1:0] == $past(ptr_o[PW-1:0]) + 1'b1));

  // R7
  full_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_i && !ld_addr_i && !wr_byte_i) |=> ptr_o == $past(ptr_o) + 1'b1);

  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !ld_addr_i && !wr_byte_i && !rd_adv_i) |=> $stable(ptr_o));

  // R9
  blocked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !ld_addr_i && !wr_byte_i && !rd_adv_i && !perm_lo_i && !perm_hi_i)
      |=> $stable(rdata_o));

endmodule

bind pgwb_top pgwb_chk #(.AW(AW), .PW(PW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_addr_i (ld_addr_i),
  .addr_i    (addr_i),
  .wr_byte_i (wr_byte_i),
  .rd_adv_i  (rd_adv_i),
  .commit_i  (commit_i),
  .perm_lo_i (perm_lo_i),
  .perm_hi_i (perm_hi_i),
  .ptr_o     (ptr_o),
  .rdata_o   (rdata_o)
);

// File: tb/pgwb_top_tb_top.sv
`timescale 1ns/1ps
module pgwb_top_tb_top;

  logic       clk;
  logic       rst_n;
  logic       ld_addr_i, wr_byte_i, rd_adv_i, commit_i;
  logic       perm_lo_i, perm_hi_i;
  logic [7:0] addr_i, wdata_i;
  logic [7:0] ptr_o, rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pgwb_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_addr_i (ld_addr_i),
    .addr_i    (addr_i),
    .wr_byte_i (wr_byte_i),
    .wdata_i   (wdata_i),
    .rd_adv_i  (rd_adv_i),
    .commit_i  (commit_i),
    .perm_lo_i (perm_lo_i),
    .perm_hi_i (perm_hi_i),
    .ptr_o     (ptr_o),
    .rdata_o   (rdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one clock with the given strobes; returns at the following falling edge
  task automatic step(input bit ld, input bit wr, input bit rd, input bit cm,
                      input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_addr_i = ld; wr_byte_i = wr; rd_adv_i = rd; commit_i = cm;
    addr_i = a; wdata_i = d;
    @(negedge clk);
    ld_addr_i = 0; wr_byte_i = 0; rd_adv_i = 0; commit_i = 0;
  endtask

  task automatic load(input logic [7:0] a);   step(1, 0, 0, 0, a, 8'h00); endtask
  task automatic put(input logic [7:0] d);    step(0, 1, 0, 0, 8'h00, d); endtask
  task automatic commit();                    step(0, 0, 0, 1, 8'h00, 8'h00); endtask

  task automatic peek(input string req, input logic [7:0] a, input logic [7:0] exp);
    load(a);
    check(req, $sformatf("byte @%02h", a), rdata_o, exp);
  endtask

  task automatic t_reset();
    check("R1", "counter", ptr_o, 8'h00);
    check("R1", "rdata", rdata_o, 8'h00);
    peek("R1", 8'h7f, 8'h00);
    peek("R1", 8'hff, 8'h00);
  endtask

  task automatic t_single();
    perm_lo_i = 1; perm_hi_i = 1;
    load(8'h85);
    check("R2", "counter after load", ptr_o, 8'h85);
    put(8'ha1);
    commit();
    check("R6", "counter after commit", ptr_o, 8'h86);
    peek("R5", 8'h85, 8'ha1);
    peek("R5", 8'h84, 8'h00);
    peek("R5", 8'h86, 8'h00);
  endtask

  task automatic t_wrap();
    load(8'h9e);
    put(8'h11); put(8'h22);
    check("R3", "counter at page end wrap", ptr_o, 8'h90);
    put(8'h33); put(8'h44);
    commit();
    check("R6", "counter after wrapped burst", ptr_o, 8'h92);
    peek("R3", 8'h9e, 8'h11);
    peek("R3", 8'h9f, 8'h22);
    peek("R3", 8'h90, 8'h33);
    peek("R3", 8'h91, 8'h44);
    peek("R5", 8'ha0, 8'h00);
    peek("R5", 8'h92, 8'h00);
  endtask

  task automatic t_overrun();
    load(8'hc0);
    for (int i = 1; i <= 18; i++) put(8'(i));
    commit();
    check("R6", "counter after 18 bytes", ptr_o, 8'hc2);
    peek("R4", 8'hc0, 8'd17);
    peek("R4", 8'hc1, 8'd18);
    peek("R4", 8'hc2, 8'd3);
    peek("R4", 8'hcf, 8'd16);
  endtask

  task automatic t_seq_read();
    load(8'hfe); put(8'h5a); put(8'h5b); commit();
    load(8'h00); put(8'h77); commit();
    load(8'hfe);
    check("R8", "rdata at fe", rdata_o, 8'h5a);
    step(0, 0, 1, 0, 8'h00, 8'h00);
    check("R7", "counter fe->ff", ptr_o, 8'hff);
    check("R8", "rdata at ff", rdata_o, 8'h5b);
    step(0, 0, 1, 0, 8'h00, 8'h00);
    check("R7", "counter roll ff->00", ptr_o, 8'h00);
    check("R8", "rdata at 00", rdata_o, 8'h77);
  endtask

  task automatic t_protect();
    perm_lo_i = 0; perm_hi_i = 1;
    load(8'h10); put(8'hee); commit();
    peek("R9", 8'h10, 8'h00);
    load(8'h20); put(8'h31); commit();
    perm_lo_i = 1;
    commit();
    peek("R10", 8'h20, 8'h00);
    perm_lo_i = 1; perm_hi_i = 0;
    load(8'ha0); put(8'h42); commit();
    peek("R9", 8'ha0, 8'h00);
    perm_hi_i = 1;
    load(8'h30); put(8'h5c); commit();
    peek("R9", 8'h30, 8'h5c);
  endtask

  task automatic t_reload();
    load(8'h40); put(8'h99);
    load(8'h48); put(8'h12); commit();
    peek("R10", 8'h40, 8'h00);
    peek("R10", 8'h48, 8'h12);
  endtask

  task automatic t_priority();
    load(8'h50);
    step(1, 1, 0, 0, 8'h60, 8'h55);
    check("R11", "counter on load+data", ptr_o, 8'h60);
    commit();
    peek("R11", 8'h60, 8'h00);
    load(8'h70);
    step(0, 1, 1, 0, 8'h00, 8'h66);
    check("R11", "counter on data+advance", ptr_o, 8'h71);
    commit();
    peek("R11", 8'h70, 8'h66);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ld_addr_i = 0; wr_byte_i = 0; rd_adv_i = 0; commit_i = 0;
    perm_lo_i = 1; perm_hi_i = 1; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overrun();
    t_seq_read();
    t_protect();
    t_reload();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule